// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer whose write side and read side each run on their own clock. Words of `DATA_W` bits (9 by default) are stored in a memory of `DEPTH` words (256 by default). The write pointer and the read pointer cross between the two clock domains as Gray codes through two-flop synchronisers. Every flag output is active low and belongs to one domain. The read domain owns empty and almost-empty. The write domain owns full and almost-full. A flag computed from a pointer that has crossed domains may release late, but it never releases early.

Two offsets set the almost thresholds, and both can be changed while the block runs. The pin `wr_en2_ld` is sampled while reset is held, and it picks the mode. If it is high, the pin is a second, active-high write enable. If it is low, the block is in load mode and the pin becomes an active-low load strobe. In load mode the write port loads the two offsets and the read port returns them, both in a fixed alternating order. The read data bus has an active-low output enable, and it shows up at the ports as a drive-enable flag.

Top module: `dcfifo_pflag`

## Requirements
- R1: A word on `wdata` is stored on a rising `wr_clk` edge when `wr_en_n` is low and `wr_en2_ld` is high. This holds in both modes.
- R2: A read happens on a rising `rd_clk` edge when `rd_en_a_n` and `rd_en_b_n` are both low and the cycle is not an offset readback. The oldest word then appears on `rdata` just after that edge. If only one of the two enables is low, nothing is read and `rdata` holds.
- R3: Reset is synchronous and active low, and it is applied in both clock domains. It clears both pointers and clears `rdata` to 0. It drives `empty_n` and `aempty_n` low and `full_n` and `afull_n` high. It sets both offsets to `DEF_OFS` (7), and it points both the load order and the readback order at the almost-empty offset.
- R4: `wr_en2_ld` is sampled on the clock edges that fall while `rst_n` is low. A 1 selects two-enable mode, in which the pin never causes a load or a readback. A 0 selects load mode.
- R5: While `full_n` is low, write requests leave the stored contents unchanged. While `empty_n` is low, read requests leave `rdata` unchanged.
- R6: With n words stored, `empty_n` is low exactly when n is 0. `aempty_n` is low exactly when n is at most the almost-empty offset. Both flags are registered in the `rd_clk` domain, and neither is ever high while the true count is at or below its threshold.
- R7: `full_n` is low exactly when n equals `DEPTH`. `afull_n` is low exactly when DEPTH minus n is at most the almost-full offset. Both flags belong to the `wr_clk` domain, and neither is ever high while the true free space is at or below its threshold. A write by the block's own port shows up in both flags just after that write edge.
- R8: In load mode, a `wr_clk` edge with `wr_en_n` low and `wr_en2_ld` low loads `wdata[ADDR_W-1:0]` into an offset register and stores no word. Successive loads go to the almost-empty offset first, then to the almost-full offset, and then the order repeats.
- R9: In load mode, an `rd_clk` edge with both read enables low and `wr_en2_ld` low places the next offset, zero-extended, on `rdata`. The offsets come out in the same order as in R8. A readback removes no word from the FIFO.
- R10: `rd_drive` is high exactly when `out_en_n` is low. `out_en_n` never changes `rdata`.
- R11: In two-enable mode, a write with `wr_en2_ld` low stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Synchronous active-low reset, held across edges of both clocks |
| wdata | input | DATA_W | Write data; the low ADDR_W bits are the offset value during a load |
| wr_en_n | input | 1 | Active-low write enable |
| wr_en2_ld | input | 1 | Mode pin: second active-high write enable, or active-low load strobe in load mode |
| rd_en_a_n | input | 1 | First active-low read enable |
| rd_en_b_n | input | 1 | Second active-low read enable |
| out_en_n | input | 1 | Active-low output enable |
| rdata | output | DATA_W | Registered read data or offset readback |
| rd_drive | output | 1 | High when `rdata` would be driven |
| empty_n | output | 1 | Active-low empty flag, read domain |
| aempty_n | output | 1 | Active-low almost-empty flag, read domain |
| full_n | output | 1 | Active-low full flag, write domain |
| afull_n | output | 1 | Active-low almost-full flag, write domain |

## Verification
Read data and readback values are updated by the `rd_clk` edge that accepts the request. The bench therefore compares `rdata` one time unit after that edge. A write or a load takes effect at its own `wr_clk` edge, and `full_n` and `afull_n` are sampled one time unit later. A change on the other side reaches a flag only after two or three edges of the destination clock. For that reason, exact flag values are compared only after the bench lets five edges of each clock pass without traffic. During concurrent random traffic with unrelated clock periods, the bench checks only that no flag releases early compared with the reference queue. The input changes and the samples are placed on time units that never coincide with a clock edge.

// File: rtl/dcfifo_pflag_pkg.sv
// Shared types for the dual-clock FIFO.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dcfifo_pflag_pkg;

    // Which offset register the next load or readback addresses.
    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;

endpackage

// File: rtl/dcfifo_pflag_mem.sv
// Storage array: one synchronous write port on the write clock and an
// asynchronous read port addressed from the read domain.
// Assumes the controllers never write a slot that has not yet been read.
module dcfifo_pflag_mem #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 8
) (
    input  logic              wr_clk,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rq
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Write one word per accepted write edge.
    always_ff @(posedge wr_clk) begin
        if (wr_go) begin
            store[waddr] <= wdata;
        end
    end

    // Combinational read; the read controller registers the result.
    assign rq = store[raddr];

endmodule

// File: rtl/dcfifo_pflag_xing.sv
// Carries a Gray-coded pointer into another clock domain through a
// parameterised chain of flops and returns it converted to binary.
// Assumes the source changes at most one bit per source clock cycle.
module dcfifo_pflag_xing #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         dst_clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [STAGES-1:0][W-1:0] chain;
    logic [W-1:0]             sync_g;

    // Shift the Gray value through the synchroniser chain.
    always_ff @(posedge dst_clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], gray_in};
        end
    end

    assign sync_g = chain[STAGES-1];

    // Gray to binary: each bit is the XOR of all Gray bits at or above it.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin_out[i] = ^(sync_g >> i);
    end

endmodule

// File: rtl/dcfifo_pflag_wside.sv
// Write-domain controller: accepts writes, owns the write pointer and its
// Gray copy, holds both offset registers and produces full/almost-full.
// Assumes rptr_bin is already synchronised into wr_clk, and that offsets
// are loaded only while the read side is idle.
module dcfifo_pflag_wside
    import dcfifo_pflag_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DEF_OFS = 7
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              we_a_n,
    input  logic              we_b_ld,
    input  logic [ADDR_W-1:0] ofs_in,
    input  logic [ADDR_W:0]   rptr_bin,
    output logic              wr_go,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              full_n,
    output logic              afull_n,
    output logic [ADDR_W-1:0] ae_ofs,
    output logic [ADDR_W-1:0] af_ofs
);
    localparam int CNT_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic             two_en_q;
    ofs_sel_e         ld_sel_q;
    logic [CNT_W-1:0] wptr_q, wptr_nx, wcount, free_cnt;
    logic             wr_req, ld_req;

    // Capture the mode pin while reset is held.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            two_en_q <= we_b_ld;
        end
    end

    // A data write needs the second enable high; in load mode that is "no load".
    assign wr_req  = !we_a_n && we_b_ld;
    assign ld_req  = !two_en_q && !we_b_ld && !we_a_n;
    assign wr_go   = wr_req && full_n;
    assign wptr_nx = wptr_q + 1'b1;
    assign waddr   = wptr_q[ADDR_W-1:0];

    // Advance the binary and Gray write pointers together.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            wgray  <= '0;
        end else if (wr_go) begin
            wptr_q <= wptr_nx;
            wgray  <= wptr_nx ^ (wptr_nx >> 1);
        end
    end

    // Load offsets in alternating order, almost-empty first.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            ae_ofs   <= ADDR_W'(DEF_OFS);
            af_ofs   <= ADDR_W'(DEF_OFS);
            ld_sel_q <= SEL_AE;
        end else if (ld_req) begin
            if (ld_sel_q == SEL_AE) begin
                ae_ofs <= ofs_in;
            end else begin
                af_ofs <= ofs_in;
            end
            ld_sel_q <= (ld_sel_q == SEL_AE) ? SEL_AF : SEL_AE;
        end
    end

    // Flags from the own pointer and the lagging read pointer (pessimistic).
    assign wcount   = wptr_q - rptr_bin;
    assign free_cnt = CNT_W'(DEPTH) - wcount;
    assign full_n   = (wcount != CNT_W'(DEPTH));
    assign afull_n  = (free_cnt > {1'b0, af_ofs});

    // R5: a write request while full must not move the pointer.
    assert_no_overflow_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!full_n && wr_req) |=> $stable(wptr_q))
        else $error("write accepted while full");

    // R7: full implies almost-full.
    assert_full_in_afull_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !afull_n)
        else $error("full without almost-full");

    // R6: the Gray pointer sent across changes by at most one bit per edge.
    assert_gray_step_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $onehot0(wgray ^ $past(wgray)))
        else $error("write Gray pointer jumped");

    // R8: an offset load stores no data word.
    assert_load_no_push_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ld_req |=> $stable(wptr_q))
        else $error("load moved write pointer");

    // R3: reset leaves full and almost-full released.
    assert_reset_wflags_R3: assert property (@(posedge wr_clk)
        !rst_n |=> (full_n && afull_n))
        else $error("write flags wrong after reset");

endmodule

// File: rtl/dcfifo_pflag_rside.sv
// Read-domain controller: accepts reads, owns the read pointer and its Gray
// copy, registers the output word or an offset readback, and produces
// empty/almost-empty.
// Assumes wptr_bin is already synchronised into rd_clk, and that the offsets
// are stable while readback or flag evaluation uses them.
module dcfifo_pflag_rside
    import dcfifo_pflag_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 8
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              re_a_n,
    input  logic              re_b_n,
    input  logic              we_b_ld,
    input  logic [ADDR_W:0]   wptr_bin,
    input  logic [ADDR_W-1:0] ae_ofs,
    input  logic [ADDR_W-1:0] af_ofs,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] rdata,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int CNT_W = ADDR_W + 1;
    localparam int PAD_W = DATA_W - ADDR_W;

    logic             two_en_q;
    ofs_sel_e         rb_sel_q;
    logic [CNT_W-1:0] rptr_q, rptr_nx, rcount;
    logic             rd_req, rb_req, rd_go;

    // Capture the mode pin while reset is held.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            two_en_q <= we_b_ld;
        end
    end

    // Both enables low reads; in load mode a low strobe turns it into readback.
    assign rd_req  = !re_a_n && !re_b_n;
    assign rb_req  = rd_req && !two_en_q && !we_b_ld;
    assign rd_go   = rd_req && !rb_req && empty_n;
    assign rptr_nx = rptr_q + 1'b1;
    assign raddr   = rptr_q[ADDR_W-1:0];

    // Advance the binary and Gray read pointers together.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rptr_q <= '0;
            rgray  <= '0;
        end else if (rd_go) begin
            rptr_q <= rptr_nx;
            rgray  <= rptr_nx ^ (rptr_nx >> 1);
        end
    end

    // Register the output word or the next offset in readback order.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rb_sel_q <= SEL_AE;
        end else if (rb_req) begin
            rdata    <= (rb_sel_q == SEL_AE) ? {{PAD_W{1'b0}}, ae_ofs}
                                             : {{PAD_W{1'b0}}, af_ofs};
            rb_sel_q <= (rb_sel_q == SEL_AE) ? SEL_AF : SEL_AE;
        end else if (rd_go) begin
            rdata <= mem_q;
        end
    end

    // Flags from the own pointer and the lagging write pointer (pessimistic).
    assign rcount   = wptr_bin - rptr_q;
    assign empty_n  = (rcount != '0);
    assign aempty_n = (rcount > {1'b0, ae_ofs});

    // R5: a read request while empty leaves pointer and output alone.
    assert_no_underflow_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!empty_n && rd_req && !rb_req) |=> ($stable(rptr_q) && $stable(rdata)))
        else $error("read accepted while empty");

    // R6: empty implies almost-empty.
    assert_empty_in_aempty_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n)
        else $error("empty without almost-empty");

    // R9: readback never consumes a word.
    assert_readback_no_pop_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rb_req |=> $stable(rptr_q))
        else $error("readback moved read pointer");

    // R3: reset asserts empty and almost-empty.
    assert_reset_rflags_R3: assert property (@(posedge rd_clk)
        !rst_n |=> (!empty_n && !aempty_n))
        else $error("read flags wrong after reset");

endmodule

// File: rtl/dcfifo_pflag.sv
// Top level of the dual-clock FIFO with programmable almost flags.
// Wires storage, the two domain controllers and the two pointer crossings.
// Assumes DEPTH is a power of two, DATA_W > log2(DEPTH), and rst_n is held
// low across several edges of both clocks.
module dcfifo_pflag #(
    parameter int DATA_W  = 9,
    parameter int DEPTH   = 256,
    parameter int DEF_OFS = 7,
    parameter int SYNC_N  = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en_n,
    input  logic              wr_en2_ld,
    input  logic              rd_en_a_n,
    input  logic              rd_en_b_n,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_drive,
    output logic              empty_n,
    output logic              aempty_n,
    output logic              full_n,
    output logic              afull_n
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = ADDR_W + 1;

    logic              wr_go;
    logic [ADDR_W-1:0] waddr, raddr, ae_ofs, af_ofs;
    logic [CNT_W-1:0]  wgray, rgray, wptr_in_rd, rptr_in_wr;
    logic [DATA_W-1:0] mem_q;

    dcfifo_pflag_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wr_clk (wr_clk),
        .wr_go  (wr_go),
        .waddr  (waddr),
        .wdata  (wdata),
        .raddr  (raddr),
        .rq     (mem_q)
    );

    dcfifo_pflag_wside #(.ADDR_W(ADDR_W), .DEF_OFS(DEF_OFS)) u_wside (
        .wr_clk   (wr_clk),
        .rst_n    (rst_n),
        .we_a_n   (wr_en_n),
        .we_b_ld  (wr_en2_ld),
        .ofs_in   (wdata[ADDR_W-1:0]),
        .rptr_bin (rptr_in_wr),
        .wr_go    (wr_go),
        .waddr    (waddr),
        .wgray    (wgray),
        .full_n   (full_n),
        .afull_n  (afull_n),
        .ae_ofs   (ae_ofs),
        .af_ofs   (af_ofs)
    );

    dcfifo_pflag_rside #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rside (
        .rd_clk   (rd_clk),
        .rst_n    (rst_n),
        .re_a_n   (rd_en_a_n),
        .re_b_n   (rd_en_b_n),
        .we_b_ld  (wr_en2_ld),
        .wptr_bin (wptr_in_rd),
        .ae_ofs   (ae_ofs),
        .af_ofs   (af_ofs),
        .mem_q    (mem_q),
        .raddr    (raddr),
        .rgray    (rgray),
        .rdata    (rdata),
        .empty_n  (empty_n),
        .aempty_n (aempty_n)
    );

    dcfifo_pflag_xing #(.W(CNT_W), .STAGES(SYNC_N)) u_w2r (
        .dst_clk (rd_clk),
        .rst_n   (rst_n),
        .gray_in (wgray),
        .bin_out (wptr_in_rd)
    );

    dcfifo_pflag_xing #(.W(CNT_W), .STAGES(SYNC_N)) u_r2w (
        .dst_clk (wr_clk),
        .rst_n   (rst_n),
        .gray_in (rgray),
        .bin_out (rptr_in_wr)
    );

    // Output enable is reported as a drive-enable flag.
    assign rd_drive = !out_en_n;

endmodule

// File: tb/dcfifo_pflag_tb.sv
module dcfifo_pflag_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = 14;
    localparam int DW         = 9;
    localparam int DEPTH      = 256;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          we1_n = 1'b1, we2_ld = 1'b1;
    logic          re1_n = 1'b1, re2_n = 1'b1, oe_n = 1'b1;
    logic [DW-1:0] rdata;
    logic          rd_drive, empty_n, aempty_n, full_n, afull_n;

    always #(CLK_PERIOD/2) wclk = ~wclk;
    always #(RD_PERIOD/2)  rclk = ~rclk;

    dcfifo_pflag u_dut (
        .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .wdata(wdata),
        .wr_en_n(we1_n), .wr_en2_ld(we2_ld), .rd_en_a_n(re1_n), .rd_en_b_n(re2_n),
        .out_en_n(oe_n), .rdata(rdata), .rd_drive(rd_drive), .empty_n(empty_n),
        .aempty_n(aempty_n), .full_n(full_n), .afull_n(afull_n)
    );

    int            n_chk = 0, n_bad = 0;
    logic [DW-1:0] q[$];
    int            ae_m = 7, af_m = 7;
    logic [DW-1:0] last_rd = '0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    function automatic int exp_empty_n(int n);  return (n != 0) ? 1 : 0;        endfunction
    function automatic int exp_aempty_n(int n); return (n > ae_m) ? 1 : 0;      endfunction
    function automatic int exp_full_n(int n);   return (n != DEPTH) ? 1 : 0;    endfunction
    function automatic int exp_afull_n(int n);  return (DEPTH - n > af_m) ? 1 : 0; endfunction

    // Exact flag check after a quiet period (R6, R7).
    task automatic check_flags(input string ctx);
        int n = q.size();
        check_eq($sformatf("R6 empty_n %s n=%0d", ctx, n), int'(empty_n), exp_empty_n(n));
        check_eq($sformatf("R6 aempty_n %s n=%0d", ctx, n), int'(aempty_n), exp_aempty_n(n));
        check_eq($sformatf("R7 full_n %s n=%0d", ctx, n), int'(full_n), exp_full_n(n));
        check_eq($sformatf("R7 afull_n %s n=%0d", ctx, n), int'(afull_n), exp_afull_n(n));
    endtask

    task automatic settle();
        repeat (5) @(posedge wclk);
        repeat (5) @(posedge rclk);
        #1;
    endtask

    task automatic do_reset(input bit two_en);
        rst_n = 1'b0; we2_ld = two_en; we1_n = 1'b1; re1_n = 1'b1; re2_n = 1'b1;
        repeat (4) @(posedge wclk);
        repeat (4) @(posedge rclk);
        #1;
        rst_n = 1'b1; we2_ld = 1'b1;
        q.delete(); ae_m = 7; af_m = 7; last_rd = '0;
    endtask

    task automatic wr_word(input logic [DW-1:0] d);
        bit acc;
        @(posedge wclk); #1;
        acc = full_n; we1_n = 1'b0; wdata = d;
        @(posedge wclk);
        if (acc) q.push_back(d);
        #1; we1_n = 1'b1;
    endtask

    task automatic rd_word(input bit a_n, input bit b_n, input bit ld, input string tag);
        bit acc;
        logic [DW-1:0] expv;
        @(posedge rclk); #1;
        acc = empty_n && !a_n && !b_n; re1_n = a_n; re2_n = b_n; we2_ld = ld;
        @(posedge rclk);
        expv = last_rd;
        if (acc && q.size() > 0) expv = q.pop_front();
        #1; re1_n = 1'b1; re2_n = 1'b1; we2_ld = 1'b1;
        check_eq(tag, int'(rdata), int'(expv));
        last_rd = expv;
    endtask

    task automatic ld_word(input logic [DW-1:0] v);
        @(posedge wclk); #1;
        we2_ld = 1'b0; we1_n = 1'b0; wdata = v;
        @(posedge wclk); #1;
        we1_n = 1'b1; we2_ld = 1'b1;
    endtask

    task automatic rb_word(input int expv, input string tag);
        @(posedge rclk); #1;
        we2_ld = 1'b0; re1_n = 1'b0; re2_n = 1'b0;
        @(posedge rclk); #1;
        re1_n = 1'b1; re2_n = 1'b1; we2_ld = 1'b1;
        check_eq(tag, int'(rdata), expv);
        last_rd = rdata;
    endtask

    task automatic drain(input string tag);
        settle();
        while (q.size() > 0) rd_word(1'b0, 1'b0, 1'b1, tag);
    endtask

    task automatic rnd_writer();
        bit go, acc;
        logic [DW-1:0] d;
        @(posedge wclk); #1;
        for (int i = 0; i < 1200; i++) begin
            go = ($urandom % 100) < ((i < 600) ? 85 : 15);
            d  = DW'($urandom);
            if (full_n) check(q.size() < DEPTH, "R7 full_n released early", q.size(), DEPTH - 1);
            if (afull_n) check(DEPTH - q.size() > af_m, "R7 afull_n released early",
                               DEPTH - q.size(), af_m + 1);
            acc = go && full_n; we1_n = !go; wdata = d;
            @(posedge wclk);
            if (acc) q.push_back(d);
            #1;
        end
        we1_n = 1'b1;
    endtask

    task automatic rnd_reader();
        bit go, acc;
        logic [DW-1:0] expv;
        @(posedge rclk); #1;
        for (int i = 0; i < 1100; i++) begin
            go = ($urandom % 100) < ((i < 430) ? 25 : 90);
            if (empty_n) check(q.size() > 0, "R6 empty_n released early", q.size(), 1);
            if (aempty_n) check(q.size() > ae_m, "R6 aempty_n released early", q.size(), ae_m + 1);
            acc = go && empty_n; re1_n = !go; re2_n = !go;
            @(posedge rclk);
            expv = last_rd;
            if (acc && q.size() > 0) expv = q.pop_front();
            #1;
            if (acc) begin
                check_eq("R1 R2 random traffic order", int'(rdata), int'(expv));
                last_rd = expv;
            end
        end
        re1_n = 1'b1; re2_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog R2 actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // Two-enable mode.
        do_reset(1'b1);
        check_eq("R3 empty_n after reset", int'(empty_n), 0);
        check_eq("R3 aempty_n after reset", int'(aempty_n), 0);
        check_eq("R3 full_n after reset", int'(full_n), 1);
        check_eq("R3 afull_n after reset", int'(afull_n), 1);
        check_eq("R3 rdata after reset", int'(rdata), 0);

        check_eq("R10 drive off", int'(rd_drive), 0);
        oe_n = 1'b0; #1;
        check_eq("R10 drive on", int'(rd_drive), 1);
        check_eq("R10 rdata unaffected", int'(rdata), 0);
        oe_n = 1'b1; #1;
        check_eq("R10 drive off again", int'(rd_drive), 0);

        // R11: second enable low blocks writes.
        @(posedge wclk); #1;
        we1_n = 1'b0; we2_ld = 1'b0; wdata = 9'h1AA;
        repeat (4) @(posedge wclk);
        #1; we1_n = 1'b1; we2_ld = 1'b1;
        settle();
        check_flags("R11 nothing stored");

        // R5: read while empty holds rdata.
        rd_word(1'b0, 1'b0, 1'b1, "R5 read while empty holds rdata");

        // R1 fill to full with boundary flag checks.
        for (int i = 0; i < DEPTH; i++) begin
            wr_word(DW'((i * 37 + 5) % 512));
            if (q.size() inside {1, 7, 8, 248, 249}) begin
                settle();
                check_flags("R1 fill");
            end
        end
        check_eq("R7 full_n right after own write", int'(full_n), 0);
        settle();
        check_flags("full");

        // R5: writes while full are dropped.
        repeat (3) wr_word(9'h155);
        settle();
        check_flags("R5 after writes while full");

        // R2: a single low read enable does nothing.
        rd_word(1'b0, 1'b1, 1'b1, "R2 only first enable low");
        rd_word(1'b1, 1'b0, 1'b1, "R2 only second enable low");
        // R4: in two-enable mode a low pin still reads data.
        rd_word(1'b0, 1'b0, 1'b0, "R4 two-enable mode pin low reads data");

        while (q.size() > 0) begin
            rd_word(1'b0, 1'b0, 1'b1, "R1 R2 directed order");
            if (q.size() inside {249, 248, 8, 7, 1}) begin
                settle();
                check_flags("drain");
            end
        end
        settle();
        check_flags("empty again");

        // Concurrent random traffic with unrelated clocks.
        fork
            rnd_writer();
            rnd_reader();
        join
        drain("R2 drain after random");
        settle();
        check_flags("after random");

        // Load mode.
        do_reset(1'b0);
        rb_word(7, "R9 R3 default almost-empty offset");
        rb_word(7, "R9 R3 default almost-full offset");
        ld_word(9'd20);
        ld_word(9'd30);
        ae_m = 20; af_m = 30;
        settle();
        check_flags("R8 R4 load stores no word");

        for (int i = 0; i < 25; i++) wr_word(DW'(300 + i));
        settle();
        rb_word(20, "R9 readback almost-empty");
        rb_word(30, "R9 readback almost-full");
        rb_word(20, "R9 readback order wraps");
        settle();
        check_flags("R9 readback keeps count");

        while (q.size() > 21) rd_word(1'b0, 1'b0, 1'b1, "R9 first word after readback");
        settle();
        check_flags("R8 new almost-empty edge above");
        rd_word(1'b0, 1'b0, 1'b1, "R2 load mode read");
        settle();
        check_flags("R8 new almost-empty edge at");
        drain("R2 load mode drain");

        for (int i = 0; i < DEPTH - 31; i++) wr_word(DW'(i));
        settle();
        check_flags("R8 new almost-full edge above");
        wr_word(9'h0AB);
        settle();
        check_flags("R8 new almost-full edge at");
        while (q.size() < DEPTH) wr_word(9'h0CD);
        settle();
        check_flags("R7 full in load mode");
        drain("R2 final drain");
        settle();
        check_flags("final");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule